// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block connects a simple synchronous host request port to a 16-Mbit, four-bit-wide asynchronous DRAM with extended-data-out page mode. For each host access it splits the 22-bit word address into an 11-bit row half and an 11-bit column half. It presents the two halves one after the other on a shared 11-bit address bus, timed against the row and column strobes. It generates the row strobe, column strobe, write enable and output enable. For the four-bit data path it provides a separate input, a separate output and a drive enable, which an external pad ring combines into the shared bidirectional pins.

A host access is one read, one early write or one late write. For an early write, write enable falls before the column strobe. For a late write, write enable falls after the column strobe, and output enable is held high throughout. The block also keeps a free-running interval counter, derived from the clock frequency, the refresh window and the row count. When it expires, the block schedules a column-before-row refresh. A pending refresh is taken ahead of any new host request, but only once the current access has finished. The host sees a ready signal and a one-cycle read-data-valid pulse. Every strobe timing minimum is a parameter counted in clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row strobe falls while the address bus carries hostAddr[21:11]. The column strobe falls, in a host access, while the address bus carries hostAddr[10:0], and that value was already on the bus in the cycle before.
- R2: A read keeps write enable high and drives output enable low while the column strobe is low. The word is returned on rdData with rdValid high for exactly one cycle, 2+T_RCD+max(T_CAS, T_RAS-T_RCD-1) clock edges after the edge that accepted the request.
- R3: An early write (hostWrite=1, hostLate=0) drops write enable before the column strobe falls. It drives the write data in the cycle before and the cycle of that fall, with output enable high, so that the stored word equals hostWdata.
- R4: A late write (hostWrite=1, hostLate=1) first drops the column strobe with write enable high. It then drives data with output enable high. Write enable falls at least one cycle after the data drive starts, and the stored word equals hostWdata.
- R5: The data drive enable is never high while output enable is low.
- R6: A refresh drops the column strobe at least one cycle before the row strobe, with write enable high. With no host traffic, refreshes are spaced exactly CLK_MHZ*REF_WINDOW_US/REF_ROWS cycles apart.
- R7: A pending refresh wins over a host request that is waiting. A running access always completes first, so refreshes continue at the interval even under back-to-back host requests.
- R8: The row strobe stays high for at least T_RP cycles before each fall. It stays low for at least T_RAS cycles. In a host access the column strobe falls no earlier than T_RCD cycles after the row strobe, and it stays low for at least T_CAS cycles.
- R9: After reset, all four strobes are high, drive enable and rdValid are low and hostReady is high. hostReady is high only when the controller is idle with no refresh pending. A request is accepted on a clock edge where hostReq and hostReady are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostLate | input | 1 | For writes: 1 = late write ordering, 0 = early write |
| hostAddr | input | ADDR_W | Word address, row in upper half |
| hostWdata | input | DQ_W | Write word |
| hostReady | output | 1 | Controller can accept a request |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| rdData | output | DQ_W | Read word |
| dramAddr | output | ADDR_W/2 | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqIn | input | DQ_W | Data from the shared pins |
| dramDqOut | output | DQ_W | Data toward the shared pins |
| dramDqOe | output | 1 | Drive enable for the shared pins |

## Verification
A read result is due 2+T_RCD+max(T_CAS, T_RAS-T_RCD-1) edges after the accepting edge. With the bench parameters this is seven edges. The bench counts edges from that accepting edge and samples rdValid on falling edges, so it can check both the exact latency and the fact that the pulse lasts one cycle. Write results are checked by reading the word back after the controller reports ready again. The address halves are checked against what a bus model latched at the strobe edges. Refresh spacing is measured in cycles between successive refresh row-strobe falls, counting only gaps whose both ends occur while the bus is idle. Strobe timing minimums are checked on every cycle by run-length counters sampled on the falling clock edge.

// File: rtl/edo_dram_ctrl_pkg.sv
package edo_dram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RASWAIT,
    ST_COLSET,
    ST_CASLOW,
    ST_LWDRV,
    ST_LWWE,
    ST_PRECH,
    ST_REFCAS,
    ST_REFRAS
  } ctrlState_e;

  // Strobe bundle from control to datapath and pins
  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
    logic oeN;
    logic dqDrive;
    logic selCol;
    logic load;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/edo_dram_ctrl_fsm.sv
module edo_dram_ctrl_fsm
  import edo_dram_ctrl_pkg::*;
#(
  parameter int T_RP       = 3,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RAS      = 5,
  parameter int REF_CYCLES = 1562
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReq,
  input  logic    hostWrite,
  input  logic    hostLate,
  output logic    hostReady,
  output strobe_t ctl
);

  localparam int MAXT0 = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int MAXT1 = (T_CAS > T_RAS) ? T_CAS : T_RAS;
  localparam int MAXT  = ((MAXT0 > MAXT1) ? MAXT0 : MAXT1) + 2;
  localparam int CW    = $clog2(MAXT + 1) + 1;
  localparam int RW    = $clog2(REF_CYCLES + 1);

  localparam logic [CW-1:0] RCD_LAST = CW'(T_RCD - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);
  localparam logic [CW-1:0] CAS_LAST = CW'(T_CAS - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(T_RAS - 1);
  localparam logic [RW-1:0] REF_LAST = RW'(REF_CYCLES - 1);

  ctrlState_e st, stNext;
  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] rasAge;
  logic [RW-1:0] refTimer;
  logic refPending;
  logic opWrite, opLate;
  logic acceptReq;
  logic strobeDone;
  logic rasMin;

  assign rasMin     = (rasAge >= RAS_LAST);
  assign strobeDone = (phaseCnt >= CAS_LAST) && rasMin;
  assign hostReady  = (st == ST_IDLE) && !refPending;

  always_comb begin
    stNext    = st;
    acceptReq = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (refPending) begin
          stNext = ST_REFCAS;
        end else if (hostReq) begin
          stNext    = ST_ROWSET;
          acceptReq = 1'b1;
        end
      end
      ST_ROWSET:  stNext = ST_RASWAIT;
      ST_RASWAIT: if (phaseCnt == RCD_LAST) stNext = ST_COLSET;
      ST_COLSET:  stNext = ST_CASLOW;
      ST_CASLOW: begin
        if (opWrite && opLate) stNext = ST_LWDRV;
        else if (strobeDone)   stNext = ST_PRECH;
      end
      ST_LWDRV:   stNext = ST_LWWE;
      ST_LWWE:    if (strobeDone) stNext = ST_PRECH;
      ST_PRECH:   if (phaseCnt == RP_LAST) stNext = ST_IDLE;
      ST_REFCAS:  stNext = ST_REFRAS;
      ST_REFRAS:  if (rasMin) stNext = ST_PRECH;
      default:    stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      phaseCnt <= '0;
      opWrite  <= 1'b0;
      opLate   <= 1'b0;
    end else begin
      st <= stNext;
      if (stNext != st)        phaseCnt <= '0;
      else if (phaseCnt != '1) phaseCnt <= phaseCnt + 1'b1;
      if (acceptReq) begin
        opWrite <= hostWrite;
        opLate  <= hostLate;
      end
    end
  end

  // Cycles the row strobe has already been low in this activation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rasAge <= '0;
    else if (ctl.rasN)        rasAge <= '0;
    else if (rasAge != '1)    rasAge <= rasAge + 1'b1;
  end

  // Refresh interval timer, free running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      if (st == ST_IDLE && refPending) refPending <= 1'b0;
      if (refTimer == REF_LAST) begin
        refTimer   <= '0;
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer + 1'b1;
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.rasN    = 1'b1;
    ctl.casN    = 1'b1;
    ctl.weN     = 1'b1;
    ctl.oeN     = 1'b1;
    ctl.load    = acceptReq;
    unique case (st)
      ST_RASWAIT: ctl.rasN = 1'b0;
      ST_COLSET: begin
        ctl.rasN    = 1'b0;
        ctl.selCol  = 1'b1;
        ctl.weN     = !(opWrite && !opLate);
        ctl.dqDrive = opWrite && !opLate;
      end
      ST_CASLOW: begin
        ctl.rasN    = 1'b0;
        ctl.casN    = 1'b0;
        ctl.selCol  = 1'b1;
        ctl.weN     = !(opWrite && !opLate);
        ctl.dqDrive = opWrite && !opLate;
        ctl.oeN     = opWrite;
        ctl.capture = !opWrite && strobeDone;
      end
      ST_LWDRV: begin
        ctl.rasN    = 1'b0;
        ctl.casN    = 1'b0;
        ctl.selCol  = 1'b1;
        ctl.dqDrive = 1'b1;
      end
      ST_LWWE: begin
        ctl.rasN    = 1'b0;
        ctl.casN    = 1'b0;
        ctl.selCol  = 1'b1;
        ctl.weN     = 1'b0;
        ctl.dqDrive = 1'b1;
      end
      ST_REFCAS: ctl.casN = 1'b0;
      ST_REFRAS: begin
        ctl.rasN = 1'b0;
        ctl.casN = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/edo_dram_ctrl_dp.sv
module edo_dram_ctrl_dp
  import edo_dram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DQ_W   = 4,
  localparam int PIN_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DQ_W-1:0]   hostWdata,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [PIN_W-1:0]  dramAddr,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic [DQ_W-1:0]   rdData,
  output logic              rdValid
);

  logic [PIN_W-1:0] rowQ, colQ;
  logic [DQ_W-1:0]  wdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
      wdQ  <= '0;
    end else if (ctl.load) begin
      rowQ <= hostAddr[ADDR_W-1:PIN_W];
      colQ <= hostAddr[PIN_W-1:0];
      wdQ  <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= dqIn;
    end
  end

  assign dramAddr = ctl.selCol ? colQ : rowQ;
  assign dqOe     = ctl.dqDrive;
  assign dqOut    = ctl.dqDrive ? wdQ : '0;

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_dram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int DQ_W          = 4,
  parameter int CLK_MHZ       = 100,
  parameter int REF_WINDOW_US = 32000,
  parameter int REF_ROWS      = 2048,
  parameter int T_RP          = 3,
  parameter int T_RCD         = 2,
  parameter int T_CAS         = 2,
  parameter int T_RAS         = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostReq,
  input  logic                  hostWrite,
  input  logic                  hostLate,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [DQ_W-1:0]       hostWdata,
  output logic                  hostReady,
  output logic                  rdValid,
  output logic [DQ_W-1:0]       rdData,
  output logic [ADDR_W/2-1:0]   dramAddr,
  output logic                  dramRasN,
  output logic                  dramCasN,
  output logic                  dramWeN,
  output logic                  dramOeN,
  input  logic [DQ_W-1:0]       dramDqIn,
  output logic [DQ_W-1:0]       dramDqOut,
  output logic                  dramDqOe
);

  localparam int REF_CYCLES = CLK_MHZ * REF_WINDOW_US / REF_ROWS;

  strobe_t ctl;

  edo_dram_ctrl_fsm #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS),
    .REF_CYCLES(REF_CYCLES)
  ) uFsm (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostLate(hostLate), .hostReady(hostReady), .ctl(ctl)
  );

  edo_dram_ctrl_dp #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .dqIn(dramDqIn), .dramAddr(dramAddr),
    .dqOut(dramDqOut), .dqOe(dramDqOe), .rdData(rdData), .rdValid(rdValid)
  );

  assign dramRasN = ctl.rasN;
  assign dramCasN = ctl.casN;
  assign dramWeN  = ctl.weN;
  assign dramOeN  = ctl.oeN;

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int ADDR_W = 22,
  parameter int T_RP   = 3,
  localparam int PIN_W = ADDR_W / 2,
  localparam int HW    = $clog2(T_RP + 2) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostReady,
  input logic             rdValid,
  input logic [PIN_W-1:0] dramAddr,
  input logic             dramRasN,
  input logic             dramCasN,
  input logic             dramWeN,
  input logic             dramOeN,
  input logic             dramDqOe
);

  logic [HW-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 highRun <= HW'(T_RP);
    else if (!dramRasN)        highRun <= '0;
    else if (highRun != '1)    highRun <= highRun + 1'b1;
  end

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasN) && !dramRasN) |-> $stable(dramAddr));

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_early_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasN) && !dramWeN) |-> (dramDqOe && $past(dramDqOe) && $past(!dramWeN) && dramOeN));

  assert_late_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramWeN) && $past(!dramCasN)) |-> (dramDqOe && $past(dramDqOe) && dramOeN));

  assert_no_drive_oe_R5: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> dramOeN);

  assert_cbr_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && !dramCasN) |-> ($past(!dramCasN) && dramWeN));

  assert_precharge_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (highRun >= HW'(T_RP)));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (dramRasN && dramCasN && dramWeN && !dramDqOe));

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.ADDR_W(ADDR_W), .T_RP(T_RP)) uChk (
  .clk(clk), .rstN(rstN), .hostReady(hostReady), .rdValid(rdValid),
  .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
  .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOe(dramDqOe)
);

// File: tb/sim_edo_dram_ctrl.sv
`timescale 1ns/1ps
module sim_edo_dram_ctrl;

  localparam int ADDR_W = 22;
  localparam int DQ_W   = 4;
  localparam int PIN_W  = ADDR_W / 2;
  localparam int T_RP   = 2;
  localparam int T_RCD  = 2;
  localparam int T_CAS  = 2;
  localparam int T_RAS  = 6;
  localparam int CLK_MHZ = 100;
  localparam int REF_WINDOW_US = 4096;
  localparam int REF_ROWS = 2048;
  localparam int REF_CYCLES = CLK_MHZ * REF_WINDOW_US / REF_ROWS;
  localparam int N_CAS = (T_CAS > T_RAS - T_RCD - 1) ? T_CAS : (T_RAS - T_RCD - 1);
  localparam int EXP_LAT = 2 + T_RCD + N_CAS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostWrite = 1'b0, hostLate = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DQ_W-1:0] hostWdata = '0;
  logic hostReady, rdValid;
  logic [DQ_W-1:0] rdData;
  logic [PIN_W-1:0] dramAddr;
  logic dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe;
  logic [DQ_W-1:0] dramDqIn, dramDqOut;

  always #5 clk = ~clk;

  edo_dram_ctrl #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .CLK_MHZ(CLK_MHZ),
    .REF_WINDOW_US(REF_WINDOW_US), .REF_ROWS(REF_ROWS),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS)
  ) u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostLate(hostLate), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostReady(hostReady), .rdValid(rdValid), .rdData(rdData),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqIn(dramDqIn),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- DRAM bus model ----------------
  logic [DQ_W-1:0] mem [int unsigned];
  logic [PIN_W-1:0] mRow = '0, mCol = '0;
  logic [DQ_W-1:0] readWord = '0;
  int writeNoDrive = 0;
  int cyc = 0;
  int refCount = 0;
  int lastRefCyc = -1;
  int lastGap = 0;
  int maxGap = 0;
  int cbrWeBad = 0;

  always @(posedge clk) cyc++;

  function automatic logic [DQ_W-1:0] peek(input logic [PIN_W-1:0] r, input logic [PIN_W-1:0] c);
    int unsigned k;
    k = int'({r, c});
    if (mem.exists(k)) return mem[k];
    return '0;
  endfunction

  task automatic storeWord();
    if (!dramDqOe) writeNoDrive++;
    mem[int'({mRow, mCol})] = dramDqOut;
  endtask

  always @(negedge dramRasN) begin
    if (dramCasN) mRow = dramAddr;
    else begin
      if (!dramWeN) cbrWeBad++;
      if (lastRefCyc >= 0) begin
        lastGap = cyc - lastRefCyc;
        if (lastGap > maxGap) maxGap = lastGap;
      end
      lastRefCyc = cyc;
      refCount++;
    end
  end

  always @(negedge dramCasN) begin
    if (!dramRasN) begin
      mCol = dramAddr;
      readWord = peek(mRow, mCol);
      if (!dramWeN) storeWord();
    end
  end

  always @(negedge dramWeN) begin
    if (!dramRasN && !dramCasN) storeWord();
  end

  assign dramDqIn = (!dramRasN && !dramCasN && !dramOeN && dramWeN) ? readWord : '0;

  // ---------------- strobe timing and drive monitors ----------------
  int driveBad = 0;
  int timeBad = 0;
  int rasLowRun = 0, rasHighRun = 100, casLowRun = 0;
  logic prevR = 1'b1, prevC = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (dramDqOe && !dramOeN) driveBad++;  // R5
      if (!dramRasN) begin
        if (prevR) begin
          if (rasHighRun < T_RP) timeBad++;
          rasLowRun = 0;
        end
        rasLowRun++;
      end else begin
        if (!prevR) begin
          if (rasLowRun < T_RAS) timeBad++;
          rasHighRun = 0;
        end
        rasHighRun++;
      end
      if (!dramCasN) begin
        if (prevC) begin
          if (!dramRasN && (rasLowRun - 1) < T_RCD) timeBad++;
          casLowRun = 0;
        end
        casLowRun++;
      end else if (!prevC && casLowRun < T_CAS) timeBad++;
      prevR = dramRasN;
      prevC = dramCasN;
    end
  end

  // ---------------- host tasks ----------------
  task automatic waitReady();
    @(negedge clk);
    while (!hostReady) @(negedge clk);
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DQ_W-1:0] d, input bit late);
    waitReady();
    hostReq = 1'b1; hostWrite = 1'b1; hostLate = late; hostAddr = a; hostWdata = d;
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0; hostWrite = 1'b0; hostLate = 1'b0;
    waitReady();
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [DQ_W-1:0] d,
                        output int lat, output bit onePulse);
    waitReady();
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = a;
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0;
    lat = 0;
    while (!rdValid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    d = rdData;
    @(negedge clk);
    onePulse = !rdValid;
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    check(hostReady === 1'b1, "R9 reset ready", int'(hostReady), 1);
    check({dramRasN, dramCasN, dramWeN, dramOeN} === 4'b1111, "R9 reset strobes",
          int'({dramRasN, dramCasN, dramWeN, dramOeN}), 15);
    check(dramDqOe === 1'b0 && rdValid === 1'b0, "R9 reset drive/valid",
          int'({dramDqOe, rdValid}), 0);
  endtask

  task automatic testEarlyWrite();
    logic [ADDR_W-1:0] a;
    logic [DQ_W-1:0] d;
    int lat;
    bit one;
    a = {11'h5A3, 11'h0C7};
    doWrite(a, 4'h5, 1'b0);
    check(mRow == a[21:11], "R1 row half", int'(mRow), int'(a[21:11]));
    check(mCol == a[10:0], "R1 column half", int'(mCol), int'(a[10:0]));
    check(peek(a[21:11], a[10:0]) == 4'h5, "R3 early write stored",
          int'(peek(a[21:11], a[10:0])), 5);
    doRead(a, d, lat, one);
    check(d == 4'h5, "R2 read data", int'(d), 5);
    check(lat == EXP_LAT, "R2 read latency", lat, EXP_LAT);
    check(one, "R2 single-cycle valid", int'(!one), 0);
  endtask

  task automatic testLateWrite();
    logic [ADDR_W-1:0] a;
    logic [DQ_W-1:0] d;
    int lat;
    bit one;
    a = {11'h021, 11'h7FE};
    doWrite(a, 4'hA, 1'b1);
    check(peek(a[21:11], a[10:0]) == 4'hA, "R4 late write stored",
          int'(peek(a[21:11], a[10:0])), 10);
    doRead(a, d, lat, one);
    check(d == 4'hA, "R4 late write readback", int'(d), 10);
    check(writeNoDrive == 0, "R4 data driven at write strobe", writeNoDrive, 0);
  endtask

  task automatic testAddrPatterns();
    logic [DQ_W-1:0] d;
    int lat;
    bit one;
    int bad;
    bad = 0;
    // swapped halves must land in distinct locations
    doWrite({11'h123, 11'h456}, 4'h3, 1'b0);
    doWrite({11'h456, 11'h123}, 4'hC, 1'b1);
    doWrite({11'h7FF, 11'h000}, 4'h9, 1'b0);
    doWrite({11'h000, 11'h7FF}, 4'h6, 1'b1);
    doRead({11'h123, 11'h456}, d, lat, one); if (d != 4'h3) bad++;
    doRead({11'h456, 11'h123}, d, lat, one); if (d != 4'hC) bad++;
    doRead({11'h7FF, 11'h000}, d, lat, one); if (d != 4'h9) bad++;
    doRead({11'h000, 11'h7FF}, d, lat, one); if (d != 4'h6) bad++;
    check(bad == 0, "R1 swapped row/column addresses", bad, 0);
  endtask

  task automatic testRefreshIdle();
    int startCount;
    int g1;
    int g2;
    startCount = refCount;
    wait (refCount > startCount);
    wait (refCount > startCount + 1);
    g1 = lastGap;
    wait (refCount > startCount + 2);
    g2 = lastGap;
    check(g1 == REF_CYCLES, "R6 idle refresh gap 1", g1, REF_CYCLES);
    check(g2 == REF_CYCLES, "R6 idle refresh gap 2", g2, REF_CYCLES);
    check(cbrWeBad == 0, "R6 refresh with write enable high", cbrWeBad, 0);
  endtask

  task automatic testPriority();
    int startCount;
    int bad;
    logic [DQ_W-1:0] d;
    int lat;
    bit one;
    logic [ADDR_W-1:0] a;
    startCount = refCount;
    maxGap = 0;
    lastRefCyc = -1;
    bad = 0;
    // back-to-back traffic: request held high across accesses
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = {11'h123, 11'h456};
    repeat (1200) begin
      @(negedge clk);
      if (rdValid && rdData != 4'h3) bad++;
    end
    hostReq = 1'b0;
    waitReady();
    check(refCount - startCount >= 5, "R7 refreshes under load", refCount - startCount, 5);
    check(maxGap <= REF_CYCLES + 20, "R7 refresh gap under load", maxGap, REF_CYCLES + 20);
    check(bad == 0, "R7 accesses complete intact", bad, 0);
    a = {11'h456, 11'h123};
    doRead(a, d, lat, one);
    check(d == 4'hC, "R7 read after refresh traffic", int'(d), 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testEarlyWrite();
    testLateWrite();
    testAddrPatterns();
    testRefreshIdle();
    testPriority();
    repeat (5) @(negedge clk);
    check(driveBad == 0, "R5 no drive while output enabled", driveBad, 0);
    check(timeBad == 0, "R8 strobe timing minimums", timeBad, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule